// File: doc/BRIEF.md
# Matrix Keyscan Debouncer with Interrupt

This block reads up to eight push keys wired as a matrix between the digit drives of a multiplexed LED display and two active-low return inputs. It does not make its own scan timing: the display multiplexer tells it which digit is being driven and gives it a one-cycle sample strobe near the end of each digit's on-window. The block counts multiplex cycles, and 32 of them make one keyscan cycle. It tests every key once in each half, at multiplex cycle 0 and at multiplex cycle 16. A key that is seen pressed at both tests is debounced.

Two registers can be read. One is a live pressed register that holds the result of the latest test. The other is a sticky debounced register that collects new presses until it is read, and the read clears it. An active-low interrupt goes low when a keyscan cycle produces a key that was not debounced in the cycle before it. A key that is held down is reported once only. The scan limit and the per-return enable restrict which keys exist.

Top module: `key_scan_debouncer`

## Requirements
- R1: After reset, `irq_n` is 1, and reads of both registers return 0.
- R2: Sampling happens on `mux_sample` strobes. A multiplex cycle ends on the strobe whose `mux_digit` equals `scan_limit`. A keyscan cycle is 2*HALF_MUX multiplex cycles, and the tests are taken in multiplex cycles 0 and HALF_MUX. A key is debounced only if it is pressed at both tests of the same keyscan cycle.
- R3: `irq_n` goes low only in the cycle after the second test of a keyscan cycle, and only when that test produces at least one newly debounced key.
- R4: Key k (k=0..3) is pressed when `mux_digit`=k and `ret_n[0]`=0. Key k+4 is pressed when `mux_digit`=k and `ret_n[1]`=0. Key k is bit k of `rd_data`.
- R5: With `scan_limit`=n-1, only keys on digits 0..n-1 can be detected. When `ret_en[j]`=0, the four keys on return j are never detected.
- R6: Debounced bits accumulate across keyscan cycles until a read with `rd_sel`=1. That read returns the accumulated value, then clears the register and returns `irq_n` to 1.
- R7: A key that is held is debounced only once. It is debounced again only after a keyscan cycle in which it was not pressed at both tests.
- R8: A read with `rd_sel`=0 returns the pressed register, which is the key vector of the latest completed test. This read changes neither the debounced register nor `irq_n`.
- R9: Any combination of the eight keys can be debounced in a single keyscan cycle.
- R10: When a clearing read lands on the same clock as the second test that produces a new key, the read returns the old value. The new key stays set afterwards and `irq_n` stays low.
- R11: The read value appears on `rd_data` in the clock after `rd_en`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mux_sample | input | 1 | One-cycle strobe near the end of the current digit window |
| mux_digit | input | 2 | Digit the multiplexer is driving now |
| scan_limit | input | 2 | Index of the last scanned digit (digits scanned = value + 1) |
| ret_en | input | 2 | Per-return keyscan enable |
| ret_n | input | 2 | Return inputs, 0 when a key on the driven digit is pressed |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 reads the pressed register, 1 reads and clears the debounced register |
| rd_data | output | 8 | Value of the last read |
| irq_n | output | 1 | Active-low new-key interrupt |

## Verification
A clearing read of the debounced register and the second test that makes a new key can fall on the same clock. The bench provokes this by raising `rd_en` with `rd_sel`=1 on the very strobe that closes multiplex cycle 16 while a fresh key is held. It expects the read to return the earlier key, the fresh key to remain set, and `irq_n` to stay low. A per-clock behavioural model judges every cycle against these expectations, and the case is also checked with literal expected values.

// File: rtl/kscan_pkg.sv
`timescale 1ns/1ps
package kscan_pkg;
  // register chosen by a read
  typedef enum logic {
    RD_PRESSED   = 1'b0,
    RD_DEBOUNCED = 1'b1
  } kreg_sel_e;
endpackage

// File: rtl/kscan_timing.sv
`timescale 1ns/1ps
// Counts multiplex cycles and marks the two test cycles of a keyscan cycle.
module kscan_timing #(
  parameter int DIGITS   = 4,
  parameter int HALF_MUX = 16,
  localparam int DW = $clog2(DIGITS),
  localparam int CW = $clog2(2 * HALF_MUX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux_sample,
  input  logic [DW-1:0] mux_digit,
  input  logic [DW-1:0] scan_limit,
  output logic          smp_en,
  output logic          test_done,
  output logic          test_second
);
  logic [CW-1:0] mcnt_q, mcnt_d;
  logic          mcnt_en;
  logic          last_slot, test_cyc, in_scan;

  always_comb begin
    in_scan     = (mux_digit <= scan_limit);
    last_slot   = mux_sample && (mux_digit == scan_limit);
    test_cyc    = (mcnt_q == '0) || (mcnt_q == CW'(HALF_MUX));
    smp_en      = mux_sample && test_cyc && in_scan;
    test_done   = last_slot && test_cyc;
    test_second = (mcnt_q == CW'(HALF_MUX));
    mcnt_en     = last_slot;
    if (mcnt_q == CW'(2 * HALF_MUX - 1)) mcnt_d = '0;
    else                                 mcnt_d = mcnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mcnt_q <= '0;
    else if (mcnt_en) mcnt_q <= mcnt_d;
  end
endmodule

// File: rtl/kscan_sampler.sv
`timescale 1ns/1ps
// Gathers the key vector of one test across the digit slots.
module kscan_sampler #(
  parameter int DIGITS  = 4,
  parameter int RETURNS = 2,
  localparam int DW   = $clog2(DIGITS),
  localparam int KEYS = DIGITS * RETURNS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_en,
  input  logic               test_done,
  input  logic [DW-1:0]      mux_digit,
  input  logic [RETURNS-1:0] ret_n,
  input  logic [RETURNS-1:0] ret_en,
  output logic [KEYS-1:0]    test_vec
);
  logic [KEYS-1:0] hit;
  logic [KEYS-1:0] acc_q, acc_d;
  logic            acc_en;

  for (genvar j = 0; j < RETURNS; j++) begin : g_ret
    for (genvar k = 0; k < DIGITS; k++) begin : g_dig
      assign hit[j*DIGITS + k] = smp_en && (mux_digit == DW'(k)) &&
                                 ret_en[j] && !ret_n[j];
    end
  end

  always_comb begin
    test_vec = acc_q | hit;
    acc_en   = smp_en || test_done;
    acc_d    = test_done ? '0 : test_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end
endmodule

// File: rtl/kscan_debounce.sv
`timescale 1ns/1ps
// Debounce decision, pressed/debounced registers, interrupt and read port.
module kscan_debounce
  import kscan_pkg::*;
#(
  parameter int KEYS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_done,
  input  logic            test_second,
  input  logic [KEYS-1:0] test_vec,
  input  logic            rd_en,
  input  logic            rd_sel,
  output logic [KEYS-1:0] rd_data,
  output logic            irq_n,
  output logic [KEYS-1:0] deb_bits,
  output logic            eval_now,
  output logic            new_any
);
  logic [KEYS-1:0] pressed_q, pressed_d;
  logic [KEYS-1:0] first_q,   first_d;
  logic [KEYS-1:0] prev_q,    prev_d;
  logic [KEYS-1:0] deb_q,     deb_d;
  logic [KEYS-1:0] rd_q,      rd_d;
  logic            irq_q,     irq_d;
  logic [KEYS-1:0] both, fresh;
  logic            clr, first_en, deb_en;

  always_comb begin
    eval_now  = test_done && test_second;
    first_en  = test_done && !test_second;
    clr       = rd_en && (rd_sel == RD_DEBOUNCED);
    both      = first_q & test_vec;
    fresh     = eval_now ? (both & ~prev_q) : '0;
    new_any   = |fresh;
    pressed_d = test_vec;
    first_d   = test_vec;
    prev_d    = both;
    deb_en    = clr || eval_now;
    deb_d     = (clr ? '0 : deb_q) | fresh;
    irq_d     = (clr ? 1'b0 : irq_q) | new_any;
    rd_d      = (rd_sel == RD_DEBOUNCED) ? deb_q : pressed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pressed_q <= '0;
      first_q   <= '0;
      prev_q    <= '0;
      deb_q     <= '0;
      irq_q     <= 1'b0;
      rd_q      <= '0;
    end else begin
      if (test_done) pressed_q <= pressed_d;
      if (first_en)  first_q   <= first_d;
      if (eval_now)  prev_q    <= prev_d;
      if (deb_en) begin
        deb_q <= deb_d;
        irq_q <= irq_d;
      end
      if (rd_en)     rd_q      <= rd_d;
    end
  end

  assign rd_data  = rd_q;
  assign irq_n    = !irq_q;
  assign deb_bits = deb_q;
endmodule

// File: rtl/key_scan_debouncer.sv
`timescale 1ns/1ps
module key_scan_debouncer #(
  parameter int DIGITS   = 4,
  parameter int RETURNS  = 2,
  parameter int HALF_MUX = 16,
  localparam int DW   = $clog2(DIGITS),
  localparam int KEYS = DIGITS * RETURNS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mux_sample,
  input  logic [DW-1:0]      mux_digit,
  input  logic [DW-1:0]      scan_limit,
  input  logic [RETURNS-1:0] ret_en,
  input  logic [RETURNS-1:0] ret_n,
  input  logic               rd_en,
  input  logic               rd_sel,
  output logic [KEYS-1:0]    rd_data,
  output logic               irq_n
);
  logic [1:0]      rs_q;
  logic            rst_int_n;
  logic            smp_en, test_done, test_second;
  logic [KEYS-1:0] test_vec;
  logic [KEYS-1:0] deb_bits;
  logic            eval_now, new_any;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  kscan_timing #(.DIGITS(DIGITS), .HALF_MUX(HALF_MUX)) u_timing (
    .clk(clk), .rst_n(rst_int_n), .mux_sample(mux_sample),
    .mux_digit(mux_digit), .scan_limit(scan_limit),
    .smp_en(smp_en), .test_done(test_done), .test_second(test_second)
  );

  kscan_sampler #(.DIGITS(DIGITS), .RETURNS(RETURNS)) u_sampler (
    .clk(clk), .rst_n(rst_int_n), .smp_en(smp_en), .test_done(test_done),
    .mux_digit(mux_digit), .ret_n(ret_n), .ret_en(ret_en),
    .test_vec(test_vec)
  );

  kscan_debounce #(.KEYS(KEYS)) u_deb (
    .clk(clk), .rst_n(rst_int_n), .test_done(test_done),
    .test_second(test_second), .test_vec(test_vec),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq_n(irq_n),
    .deb_bits(deb_bits), .eval_now(eval_now), .new_any(new_any)
  );
endmodule

// File: rtl/key_scan_debouncer_chk.sv
`timescale 1ns/1ps
module key_scan_debouncer_chk #(
  parameter int KEYS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic            rd_sel,
  input logic            irq_n,
  input logic [KEYS-1:0] deb_bits,
  input logic            eval_now,
  input logic            new_any
);
  AST_IRQ_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (deb_bits != '0)); // R3

  AST_IRQ_FALLS_AT_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(eval_now && new_any)); // R3

  AST_DEB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_sel) |=> ((deb_bits & $past(deb_bits)) == $past(deb_bits))); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && !new_any) |=> (irq_n && (deb_bits == '0))); // R6

  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && new_any) |=> !irq_n); // R10

  AST_PRESSED_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !new_any) |=> ($stable(irq_n) && $stable(deb_bits))); // R8
endmodule

bind key_scan_debouncer key_scan_debouncer_chk #(.KEYS(KEYS)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .irq_n(irq_n),
  .deb_bits(deb_bits), .eval_now(eval_now), .new_any(new_any)
);

// File: tb/key_scan_debouncer_test.sv
`timescale 1ns/1ps
module key_scan_debouncer_test;
  localparam int HALF = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mux_sample;
  logic [1:0] mux_digit;
  logic [1:0] scan_limit;
  logic [1:0] ret_en;
  logic [1:0] ret_n;
  logic       rd_en, rd_sel;
  logic [7:0] rd_data;
  logic       irq_n;

  logic [7:0] keys_down;

  always #4 clk = ~clk;

  always_comb begin
    ret_n[0] = ~keys_down[mux_digit];
    ret_n[1] = ~keys_down[4 + int'(mux_digit)];
  end

  key_scan_debouncer uut (
    .clk(clk), .rst_n(rst_n), .mux_sample(mux_sample), .mux_digit(mux_digit),
    .scan_limit(scan_limit), .ret_en(ret_en), .ret_n(ret_n),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq_n(irq_n)
  );

  int    tests = 0;
  int    fails = 0;
  bit    done  = 0;
  string cur_req = "R1";

  // behavioural reference
  int         mc = 0;
  logic [7:0] m_buf = 0, m_first = 0, m_prev = 0, m_pressed = 0, m_deb = 0;
  bit         m_irq = 0;
  logic [7:0] m_rd = 0;
  bit         rd_pending = 0;
  bit         lit_pending = 0;
  logic [7:0] lit_exp;
  string      lit_tag;
  bit         rd_on_eval = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit smp, input int dig, input bit rden, input bit rdsel);
    logic [7:0] both, newb;
    @(negedge clk);
    chk(irq_n == !m_irq, cur_req, "irq_n vs model", irq_n, !m_irq);
    if (rd_pending) chk(rd_data == m_rd, "R11", "rd_data vs model", rd_data, m_rd);
    if (lit_pending) begin
      chk(rd_data == lit_exp, lit_tag, "rd_data literal", rd_data, lit_exp);
      lit_pending = 0;
    end
    mux_sample = smp;
    mux_digit  = dig[1:0];
    rd_en      = rden;
    rd_sel     = rdsel;
    rd_pending = rden;
    if (rden) m_rd = rdsel ? m_deb : m_pressed;
    newb = 0;
    if (smp) begin
      bit tact;
      tact = (mc == 0) || (mc == HALF);
      if (tact && dig <= int'(scan_limit))
        for (int j = 0; j < 2; j++)
          if (ret_en[j] && keys_down[dig + 4*j]) m_buf[dig + 4*j] = 1'b1;
      if (dig == int'(scan_limit)) begin
        if (tact) begin
          m_pressed = m_buf;
          if (mc == HALF) begin
            both   = m_first & m_buf;
            newb   = both & ~m_prev;
            m_prev = both;
          end else m_first = m_buf;
          m_buf = 0;
        end
        mc = (mc + 1) % (2 * HALF);
      end
    end
    if (rden && rdsel) begin m_deb = 0; m_irq = 0; end
    m_deb = m_deb | newb;
    if (newb != 0) m_irq = 1;
  endtask

  task automatic mux_cycle();
    for (int d = 0; d <= int'(scan_limit); d++) begin
      step(0, d, 0, 0);
      step(0, d, 0, 0);
      step(1, d, rd_on_eval && d == int'(scan_limit) && mc == HALF, 1);
    end
  endtask

  task automatic run_mux(input int n);
    for (int i = 0; i < n; i++) mux_cycle();
  endtask

  task automatic scan_cycles(input int n);
    run_mux(n * 2 * HALF);
  endtask

  task automatic read_expect(input bit sel, input logic [7:0] exp, input string tag);
    step(0, 0, 1, sel);
    lit_pending = 1; lit_exp = exp; lit_tag = tag;
    step(0, 0, 0, 0);
  endtask

  task automatic expect_irq(input bit low, input string tag);
    step(0, 0, 0, 0);
    chk(irq_n == !low, tag, "irq_n literal", irq_n, !low);
  endtask

  task automatic clean(input string tag);
    keys_down = 0;
    cur_req = tag;
    scan_cycles(1);
    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mux_sample = 0; mux_digit = 0; scan_limit = 2'd3;
    ret_en = 2'b11; rd_en = 0; rd_sel = 0; keys_down = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);

    // R1 reset state
    cur_req = "R1";
    expect_irq(0, "R1");
    read_expect(1, 8'h00, "R1");
    read_expect(0, 8'h00, "R1");

    // R2 R3 R4 R11: one key held for a full keyscan cycle
    cur_req = "R3";
    keys_down = 8'h20;
    scan_cycles(1);
    expect_irq(1, "R3");
    read_expect(0, 8'h20, "R8");
    read_expect(1, 8'h20, "R4");
    expect_irq(0, "R6");
    read_expect(1, 8'h00, "R6");

    // R7: held key not reported again, re-armed after release
    cur_req = "R7";
    scan_cycles(1);
    expect_irq(0, "R7");
    read_expect(1, 8'h00, "R7");
    keys_down = 0;
    scan_cycles(1);
    keys_down = 8'h20;
    scan_cycles(1);
    expect_irq(1, "R7");
    read_expect(1, 8'h20, "R7");

    // R9: many keys in one cycle
    clean("R9");
    keys_down = 8'h99;
    scan_cycles(1);
    read_expect(1, 8'h99, "R9");

    // R2: key seen only at the first test is rejected
    clean("R2");
    keys_down = 8'h01;
    run_mux(HALF);
    keys_down = 0;
    run_mux(HALF);
    expect_irq(0, "R2");
    read_expect(1, 8'h00, "R2");

    // R5: scan limit and return enables
    clean("R5");
    scan_limit = 2'd1;
    keys_down = 8'hFF;
    scan_cycles(1);
    read_expect(1, 8'h33, "R5");
    clean("R5");
    scan_limit = 2'd3;
    ret_en = 2'b10;
    keys_down = 8'hFF;
    scan_cycles(1);
    read_expect(1, 8'hF0, "R5");
    ret_en = 2'b11;

    // R6: accumulation across cycles
    clean("R6");
    keys_down = 8'h02;
    scan_cycles(1);
    keys_down = 0;
    scan_cycles(1);
    keys_down = 8'h04;
    scan_cycles(1);
    expect_irq(1, "R6");
    read_expect(1, 8'h06, "R6");

    // R8: reading pressed register clears nothing
    clean("R8");
    keys_down = 8'h08;
    scan_cycles(1);
    read_expect(0, 8'h08, "R8");
    expect_irq(1, "R8");
    read_expect(1, 8'h08, "R8");

    // R10: clearing read on the same clock as a new debounced key
    clean("R10");
    keys_down = 8'h40;
    scan_cycles(1);
    keys_down = 0;
    scan_cycles(1);
    keys_down = 8'h80;
    rd_on_eval = 1;
    lit_pending = 0;
    scan_cycles(1);
    rd_on_eval = 0;
    chk(rd_data == 8'h40, "R10", "collision read value", rd_data, 8'h40);
    expect_irq(1, "R10");
    read_expect(1, 8'h80, "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule